// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block is the control front end of a synchronous static RAM with pipelined reads. On every rising clock edge it samples three chip selects, two address strobes, a burst-advance input and the write controls. From these it classifies the cycle as idle, deselect, read start, write start, read continue or write continue. It also derives the per-lane write enables and a drive enable for the data bus. Behind the controller is a behavioural storage array of 36-bit words made of four 9-bit lanes.

A burst is opened by either strobe. The processor-side strobe always opens a read. The controller-side strobe opens a write when the write controls request one, and a read otherwise. Later clocks with neither strobe continue the open burst. The address moves to the next slot of a four-word wrapping sequence when advance is low, and is held when it is high. Each continue cycle is a write or a read according to the write controls on that clock. Read data is registered, so it appears one clock after the edge that took the address. The data bus driver enable is combinational in the output-enable pin, so that pin takes effect at once, without waiting for a clock.

Top module: `sram_burst_ctrl`

## Requirements
- R1: A write is requested when `gw_n` is low, which writes all four lanes, or when `lane_gate_n` is low and at least one `lane_wr_n[i]` is low, which writes only the lanes whose bit is low. Lane i is `wdata[9*i+8:9*i]`. With `gw_n` and `lane_gate_n` high, or with the gate low and every lane bit high, no write is requested.
- R2: A clock with `cpu_strb_n` low and the chip selected opens a read burst at `addr`. Nothing is written on that clock, whatever the write controls are.
- R3: A clock with `ctl_strb_n` low, `cpu_strb_n` high and the chip selected opens a burst at `addr`. That clock is a write of `wdata` to `addr` if R1 requests a write, and a read otherwise.
- R4: On a clock after a read start, with no strobe and the burst open, a write request writes the current burst address.
- R5: A read registered on edge k presents its word on `rdata` after edge k+1.
- R6: `dq_oe` is high only while a read word is being presented, `out_en_n` is low, and the pins do not show a write cycle. It follows `out_en_n` without a clock.
- R7: A strobe clock with the chip not selected (`en_a_n` high, `en_b` low or `en_c_n` high) accesses nothing and closes the burst. The bus floats one clock later, and following continue clocks are ignored.
- R8: With `burst_lin` high, the n-th advance gives low address bits (base + n) mod 4. The upper bits are held.
- R9: With `burst_lin` low, the n-th advance gives low address bits base XOR n.
- R10: A continue clock with `adv_n` high repeats the current burst address.
- R11: After reset no burst is open and `dq_oe` is low. Continue clocks write nothing until a strobe opens a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_a_n | input | 1 | Chip select, active low |
| en_b | input | 1 | Chip select, active high |
| en_c_n | input | 1 | Chip select, active low |
| cpu_strb_n | input | 1 | Processor-side address strobe, forces a read start |
| ctl_strb_n | input | 1 | Controller-side address strobe |
| adv_n | input | 1 | Burst advance, active low |
| burst_lin | input | 1 | 1 = linear order, 0 = interleaved order |
| addr | input | 6 | Word address, taken on a start |
| gw_n | input | 1 | Global write, all lanes |
| lane_gate_n | input | 1 | Gate for the per-lane write enables |
| lane_wr_n | input | 4 | Per-lane write enables, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 36 | Write data, taken on the write edge |
| rdata | output | 36 | Registered read data |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
The hardest case to reach is a word that is held in the read register while the pins already show a write continue. This is the only moment when the write override of `dq_oe` matters. The stimulus opens a burst with the processor strobe, holds it with a suspend clock, and then asserts a write on the next continue clock. This places the override in the cycle where the older read is still being presented. Deselect and reset are each followed by continue clocks with write requests. Later reads of the addresses those writes would have hit then show that nothing changed.

// File: rtl/sram_burst_pkg.sv
`timescale 1ns/1ps
package sram_burst_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_DESEL,
    CYC_RD_START,
    CYC_WR_START,
    CYC_RD_CONT,
    CYC_WR_CONT
  } cyc_kind_e;
endpackage

// File: rtl/sram_cyc_decode.sv
`timescale 1ns/1ps
module sram_cyc_decode
  import sram_burst_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             en_a_n,
  input  logic             en_b,
  input  logic             en_c_n,
  input  logic             cpu_strb_n,
  input  logic             ctl_strb_n,
  input  logic             adv_n,
  input  logic             burst_open,
  input  logic             gw_n,
  input  logic             lane_gate_n,
  input  logic [LANES-1:0] lane_wr_n,
  output cyc_kind_e        kind,
  output logic [LANES-1:0] lane_we,
  output logic             load,
  output logic             step,
  output logic             rd_go,
  output logic             wr_go,
  output logic             start,
  output logic             sel_ok
);
  logic [LANES-1:0] req_mask;
  logic             wr_req;

  // per-lane request: global write covers every lane
  for (genvar l = 0; l < LANES; l++) begin : g_lane_req
    assign req_mask[l] = !gw_n || (!lane_gate_n && !lane_wr_n[l]);
  end
  assign wr_req = |req_mask;

  always_comb begin
    sel_ok = !en_a_n && en_b && !en_c_n;
    start  = !cpu_strb_n || !ctl_strb_n;
    kind   = CYC_IDLE;
    if (start) begin
      if (!sel_ok)          kind = CYC_DESEL;
      else if (!cpu_strb_n) kind = CYC_RD_START;
      else if (wr_req)      kind = CYC_WR_START;
      else                  kind = CYC_RD_START;
    end else if (burst_open) begin
      kind = wr_req ? CYC_WR_CONT : CYC_RD_CONT;
    end
  end

  always_comb begin
    load    = (kind == CYC_RD_START) || (kind == CYC_WR_START);
    step    = ((kind == CYC_RD_CONT) || (kind == CYC_WR_CONT)) && !adv_n;
    rd_go   = (kind == CYC_RD_START) || (kind == CYC_RD_CONT);
    wr_go   = (kind == CYC_WR_START) || (kind == CYC_WR_CONT);
    lane_we = wr_go ? req_mask : '0;
  end
endmodule

// File: rtl/sram_burst_addr.sv
`timescale 1ns/1ps
module sram_burst_addr #(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              linear,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] cur_addr
);
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] cnt_use;
  logic [BURST_W-1:0] low;
  logic [ADDR_W-1:0]  seq_addr;

  assign cnt_use = step ? cnt_q + 1'b1 : cnt_q;
  assign low     = linear ? (base_q[BURST_W-1:0] + cnt_use)
                          : (base_q[BURST_W-1:0] ^ cnt_use);

  if (ADDR_W > BURST_W) begin : g_upper
    assign seq_addr = {base_q[ADDR_W-1:BURST_W], low};
  end else begin : g_flat
    assign seq_addr = ADDR_W'(low);
  end

  assign cur_addr = load ? addr_in : seq_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= addr_in;
      cnt_q  <= '0;
    end else if (step) begin
      cnt_q  <= cnt_use;
    end
  end

  // R8 R9: each advance moves the slot counter by one, wrapping
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R10: a clock without advance or load keeps the burst base and slot
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> ($stable(cnt_q) && $stable(base_q)));
endmodule

// File: rtl/sram_lane_array.sv
`timescale 1ns/1ps
module sram_lane_array #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int ADDR_W = 6
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        lane_we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rword
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (lane_we[l]) mem[waddr] <= wdata[l*LANE_W +: LANE_W];
    end
    assign rword[l*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/sram_burst_ctrl.sv
`timescale 1ns/1ps
module sram_burst_ctrl
  import sram_burst_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_a_n,
  input  logic              en_b,
  input  logic              en_c_n,
  input  logic              cpu_strb_n,
  input  logic              ctl_strb_n,
  input  logic              adv_n,
  input  logic              burst_lin,
  input  logic [ADDR_W-1:0] addr,
  input  logic              gw_n,
  input  logic              lane_gate_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              out_en_n,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              dq_oe
);
  cyc_kind_e         kind;
  logic [LANES-1:0]  lane_we;
  logic              load, step, rd_go, wr_go, start, sel_ok;
  logic              burst_open_q;
  logic [ADDR_W-1:0] cur_addr;
  logic              rd_pend_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic              rd_valid_q;
  logic [WORD_W-1:0] rdata_q;
  logic [WORD_W-1:0] rword;

  sram_cyc_decode #(.LANES(LANES)) u_decode (
    .en_a_n      (en_a_n),
    .en_b        (en_b),
    .en_c_n      (en_c_n),
    .cpu_strb_n  (cpu_strb_n),
    .ctl_strb_n  (ctl_strb_n),
    .adv_n       (adv_n),
    .burst_open  (burst_open_q),
    .gw_n        (gw_n),
    .lane_gate_n (lane_gate_n),
    .lane_wr_n   (lane_wr_n),
    .kind        (kind),
    .lane_we     (lane_we),
    .load        (load),
    .step        (step),
    .rd_go       (rd_go),
    .wr_go       (wr_go),
    .start       (start),
    .sel_ok      (sel_ok)
  );

  sram_burst_addr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .step     (step),
    .linear   (burst_lin),
    .addr_in  (addr),
    .cur_addr (cur_addr)
  );

  sram_lane_array #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_array (
    .clk     (clk),
    .lane_we (lane_we),
    .waddr   (cur_addr),
    .wdata   (wdata),
    .raddr   (rd_addr_q),
    .rword   (rword)
  );

  // burst ownership: opened by a selected start, closed by a deselect
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  burst_open_q <= 1'b0;
    else if (kind == CYC_DESEL)  burst_open_q <= 1'b0;
    else if (load)               burst_open_q <= 1'b1;
  end

  // two-stage read pipe: address register, then data register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q  <= 1'b0;
      rd_addr_q  <= '0;
      rd_valid_q <= 1'b0;
      rdata_q    <= '0;
    end else begin
      rd_pend_q  <= rd_go;
      if (rd_go) rd_addr_q <= cur_addr;
      rd_valid_q <= rd_pend_q;
      if (rd_pend_q) rdata_q <= rword;
    end
  end

  assign rdata = rdata_q;
  assign dq_oe = rd_valid_q && !out_en_n && !wr_go;

  // R2
  cpu_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_strb_n |-> (lane_we == '0));
  // R1
  global_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gw_n && wr_go) |-> (&lane_we));
  // R6
  write_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we != '0) |-> !dq_oe);
  // R6
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !dq_oe);
  // R7
  desel_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !sel_ok) |=> (!rd_pend_q && !burst_open_q));
  // R5
  read_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend_q |=> rd_valid_q);
endmodule

// File: tb/sram_burst_ctrl_tb.sv
`timescale 1ns/1ps
module sram_burst_ctrl_tb;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int ADDR_W = 6;
  localparam int WORD_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam real CLK_PERIOD = 4.0;

  // vector: {req[19:16], kind[15:14], adv_n, gw_n, gate_n, lane_n[10:7], oe_n, addr[5:0]}
  // kind: 0 none, 1 cpu strobe, 2 ctl strobe, 3 ctl strobe deselected; req 15 = burst order (R8/R9)
  localparam int NV = 20;
  localparam logic [19:0] TBL [NV] = '{
    {4'd3,  2'd2, 1'b1, 1'b0, 1'b1, 4'hF,    1'b0, 6'h11}, // R3 write start
    {4'd15, 2'd0, 1'b0, 1'b0, 1'b1, 4'hF,    1'b0, 6'h00}, // write continue
    {4'd15, 2'd0, 1'b0, 1'b0, 1'b1, 4'hF,    1'b0, 6'h00},
    {4'd15, 2'd0, 1'b0, 1'b0, 1'b1, 4'hF,    1'b0, 6'h00},
    {4'd1,  2'd2, 1'b1, 1'b1, 1'b0, 4'b1010, 1'b0, 6'h21}, // R1 lanes 0 and 2
    {4'd2,  2'd1, 1'b1, 1'b0, 1'b0, 4'h0,    1'b0, 6'h11}, // R2 read despite writes
    {4'd15, 2'd0, 1'b0, 1'b1, 1'b1, 4'hF,    1'b0, 6'h00},
    {4'd15, 2'd0, 1'b0, 1'b1, 1'b1, 4'hF,    1'b0, 6'h00},
    {4'd15, 2'd0, 1'b0, 1'b1, 1'b1, 4'hF,    1'b0, 6'h00},
    {4'd1,  2'd1, 1'b1, 1'b1, 1'b1, 4'hF,    1'b0, 6'h21}, // R1 readback
    {4'd10, 2'd0, 1'b1, 1'b1, 1'b1, 4'hF,    1'b1, 6'h00}, // R10 suspend, R6 oe high
    {4'd4,  2'd0, 1'b1, 1'b0, 1'b1, 4'hF,    1'b0, 6'h00}, // R4 write after read start
    {4'd7,  2'd3, 1'b1, 1'b1, 1'b1, 4'hF,    1'b0, 6'h30}, // R7 deselect
    {4'd7,  2'd0, 1'b0, 1'b0, 1'b1, 4'hF,    1'b0, 6'h00}, // R7 ignored write
    {4'd4,  2'd1, 1'b1, 1'b1, 1'b1, 4'hF,    1'b0, 6'h21}, // R4 readback
    {4'd7,  2'd1, 1'b1, 1'b1, 1'b1, 4'hF,    1'b0, 6'h20}, // R7 untouched
    {4'd7,  2'd1, 1'b1, 1'b1, 1'b1, 4'hF,    1'b0, 6'h22}, // R7 untouched
    {4'd3,  2'd2, 1'b1, 1'b1, 1'b0, 4'hF,    1'b0, 6'h23}, // R3 no lane -> read
    {4'd6,  2'd0, 1'b1, 1'b1, 1'b1, 4'hF,    1'b0, 6'h00}, // R6
    {4'd6,  2'd3, 1'b1, 1'b1, 1'b1, 4'hF,    1'b0, 6'h00}  // R6 close
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_a_n = 1'b0, en_b = 1'b1, en_c_n = 1'b0;
  logic cpu_strb_n = 1'b1, ctl_strb_n = 1'b1, adv_n = 1'b1, burst_lin = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic gw_n = 1'b1, lane_gate_n = 1'b1;
  logic [LANES-1:0] lane_wr_n = '1;
  logic out_en_n = 1'b0;
  logic [WORD_W-1:0] wdata = '0;
  logic [WORD_W-1:0] rdata;
  logic dq_oe;

  int checks = 0;
  int failures = 0;
  int seq = 1;
  bit done = 1'b0;

  logic [WORD_W-1:0] ref_mem [DEPTH];
  bit m_act = 1'b0;
  logic [ADDR_W-1:0] m_base = '0;
  logic [1:0] m_cnt = '0;
  bit h_prev_rd = 1'b0, h_old_rd = 1'b0;
  logic [WORD_W-1:0] h_prev_d = '0, h_old_d = '0;
  int h_prev_tag = 0, h_old_tag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_burst_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
    .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n), .adv_n(adv_n),
    .burst_lin(burst_lin), .addr(addr), .gw_n(gw_n), .lane_gate_n(lane_gate_n),
    .lane_wr_n(lane_wr_n), .out_en_n(out_en_n), .wdata(wdata), .rdata(rdata),
    .dq_oe(dq_oe)
  );

  function automatic logic [WORD_W-1:0] wpat(input int s);
    logic [WORD_W-1:0] w;
    for (int j = 0; j < LANES; j++) w[j*LANE_W +: LANE_W] = LANE_W'(s*29 + j*7 + 3);
    return w;
  endfunction

  task automatic chk(input bit ok, input int tag, input string what,
                     input logic [WORD_W-1:0] got, input logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL R%0d %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic step(input logic [19:0] v);
    logic [3:0] rq;
    logic [1:0] kd;
    logic adv, gw, gate, oe;
    logic [3:0] ln, mask;
    logic [5:0] ad, a;
    logic [1:0] lo;
    logic [WORD_W-1:0] wd, nd;
    int op, tagn;
    bit exp_oe;
    rq = v[19:16]; kd = v[15:14]; adv = v[13]; gw = v[12]; gate = v[11];
    ln = v[10:7]; oe = v[6]; ad = v[5:0];
    tagn = (rq == 4'd15) ? (burst_lin ? 8 : 9) : int'(rq);
    a = '0; nd = '0; op = 0;
    @(negedge clk);
    en_b = (kd != 2'd3); cpu_strb_n = (kd != 2'd1);
    ctl_strb_n = !(kd == 2'd2 || kd == 2'd3);
    adv_n = adv; gw_n = gw; lane_gate_n = gate; lane_wr_n = ln; out_en_n = oe; addr = ad;
    wd = wpat(seq); wdata = wd; seq++;
    mask = !gw ? 4'hF : (!gate ? ~ln : 4'h0);
    if (kd != 2'd0) begin
      if (kd == 2'd3) m_act = 1'b0;
      else begin
        m_act = 1'b1; m_base = ad; m_cnt = 2'd0; a = ad;
        op = (kd == 2'd1) ? 1 : ((mask != 0) ? 2 : 1);
      end
    end else if (m_act) begin
      if (!adv) m_cnt = m_cnt + 2'd1;
      lo = burst_lin ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
      a = {m_base[5:2], lo};
      op = (mask != 0) ? 2 : 1;
    end
    #1;
    exp_oe = h_old_rd && !oe && (op != 2);
    chk(dq_oe === exp_oe, 6, "dq_oe", WORD_W'(dq_oe), WORD_W'(exp_oe));
    if (h_old_rd) chk(rdata === h_old_d, h_old_tag, "rdata", rdata, h_old_d);
    if (op == 2) begin
      for (int j = 0; j < LANES; j++)
        if (mask[j]) ref_mem[a][j*LANE_W +: LANE_W] = wd[j*LANE_W +: LANE_W];
    end else if (op == 1) nd = ref_mem[a];
    h_old_rd = h_prev_rd; h_old_d = h_prev_d; h_old_tag = h_prev_tag;
    h_prev_rd = (op == 1); h_prev_d = nd; h_prev_tag = tagn;
    @(posedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cpu_strb_n = 1'b1; ctl_strb_n = 1'b1; out_en_n = 1'b0;
    m_act = 1'b0; h_prev_rd = 1'b0; h_old_rd = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11: bus released after reset
    chk(dq_oe === 1'b0, 11, "dq_oe after reset", WORD_W'(dq_oe), '0);
  endtask

  initial begin
    do_reset();
    // preload every word with interleaved write bursts (R3)
    for (int b = 0; b < DEPTH/4; b++) begin
      step({4'd3, 2'd2, 1'b1, 1'b0, 1'b1, 4'hF, 1'b0, 6'(b*4)});
      for (int k = 0; k < 3; k++) step({4'd15, 2'd0, 1'b0, 1'b0, 1'b1, 4'hF, 1'b0, 6'h00});
    end
    // read everything back: R5 first word, R9 continues
    for (int b = 0; b < DEPTH/4; b++) begin
      step({4'd5, 2'd1, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 6'(b*4)});
      for (int k = 0; k < 3; k++) step({4'd15, 2'd0, 1'b0, 1'b1, 1'b1, 4'hF, 1'b0, 6'h00});
    end
    // table, interleaved then linear (R8)
    for (int p = 0; p < 2; p++) begin
      burst_lin = (p == 1);
      for (int i = 0; i < NV; i++) step(TBL[i]);
    end
    step({4'd6, 2'd0, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 6'h00});
    step({4'd6, 2'd0, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 6'h00});
    // R11: continue-with-write clocks after reset must not write
    do_reset();
    step({4'd11, 2'd0, 1'b0, 1'b0, 1'b1, 4'hF, 1'b0, 6'h00});
    step({4'd11, 2'd0, 1'b0, 1'b0, 1'b1, 4'hF, 1'b0, 6'h00});
    step({4'd11, 2'd1, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 6'h11});
    step({4'd11, 2'd0, 1'b0, 1'b1, 1'b1, 4'hF, 1'b0, 6'h00});
    step({4'd11, 2'd3, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 6'h00});
    step({4'd11, 2'd0, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 6'h00});
    step({4'd11, 2'd0, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 6'h00});
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R5 watchdog: actual running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule